// File: doc/BRIEF.md
# Pipelined Bus Slave with Programmable Wait States

This block is the slave side of a single-master, pipelined AHB-Lite bus. It fronts a small bank of word registers. An address decoder outside the block drives its select input from the upper address bits. The slave therefore sees only the byte offset inside its window and never needs to know where that window sits in the system map. In each cycle where the select, the transfer-active bit of the transfer type and the bus ready are all high, the slave latches the offset and direction of the transfer. It then performs the access in the following data phase.

The slave can stretch the data phase only, by holding its ready output low for 0 to 3 cycles. The count is taken from a configuration input at the moment the transfer is accepted. The bus ready is shared, so these wait states also hold the master's next address phase in place. An offset that maps to no register gets a two-cycle error response. A control state machine sequences each response. Its states are:
- **IDLE**: no transfer pending.
- **WAIT**: ready held low.
- **DONE**: last data-phase cycle, with ready high and the access performed.
- **ERR_LO**: first error cycle.
- **ERR_HI**: second error cycle.

Its transitions are:
- From IDLE, DONE or ERR_HI, an accepted transfer leads to ERR_LO if the offset is unmapped, to DONE if the wait count is zero, and to WAIT otherwise.
- From IDLE, DONE or ERR_HI, the absence of an accepted transfer leads to IDLE.
- From WAIT, the block moves to DONE when its wait counter is exhausted, and stays in WAIT otherwise.
- From ERR_LO, the block always moves to ERR_HI.

Top module: `ahbl_wait_slave`

## Requirements
- R1: Reset behaviour. While reset is asserted and right after it is released, `hreadyout` is 1, `hresp` is 0 and `hrdata` is 0. All registers also read as 0.
- R2: Acceptance and ignored cycles. A transfer is accepted only in a cycle with `hsel`=1, `htrans[1]`=1 and `hready`=1. IDLE (`htrans`=00) and BUSY (`htrans`=01) cycles are ignored, and so are cycles with `hsel`=0. An ignored cycle gets `hreadyout`=1 and `hresp`=0 in the next cycle, and it leaves every register unchanged.
- R3: Wait states. A mapped transfer accepted with `wait_cfg`=N (0..3) has a data phase of N cycles with `hreadyout`=0, followed by one cycle with `hreadyout`=1.
- R4: Writes. In a write (`hwrite`=1), `hwdata` is stored into the addressed register in the data-phase cycle in which `hreadyout` is 1.
- R5: Reads. In a read, `hrdata` carries the addressed register in the data-phase cycle in which `hreadyout` is 1, and is 0 in every other cycle. The register index is the word offset `haddr[ADDR_W-1:2]`, and `haddr[1:0]` is ignored.
- R6: Unmapped offsets. A word offset of NUM_REGS or more gives `hreadyout`=0 with `hresp`=1, and then `hreadyout`=1 with `hresp`=1. A write to such an offset changes no register.
- R7: Pipelining. The next transfer's address is accepted in the final cycle of the current data phase. Back-to-back zero-wait transfers therefore keep `hreadyout` high in every cycle.
- R8: Response encoding. `hresp` is 0 (OKAY) in every cycle except the two cycles of an error response, where it is 1 (ERROR).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select from the external decoder |
| haddr | input | ADDR_W | Byte offset inside the slave window |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | DATA_W | Write data, valid during the data phase |
| hready | input | 1 | Shared bus ready |
| wait_cfg | input | 2 | Number of wait states, sampled at acceptance |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR |
| hrdata | output | DATA_W | Read data |

## Verification
The bench builds the slave with NUM_REGS=6, ADDR_W=13 and DATA_W=32. A register count that is not a power of two places the first unmapped word offset, 6, inside the range of the index bits. This exposes a decode that only truncates the offset, as does the far end of the window at offset 0x1FFC. A behavioural model is compared with all three outputs on every cycle. The stimulus steps through every wait count, including back-to-back and error-to-mapped sequences, and issues ignored IDLE, BUSY and deselected cycles, which are followed by readbacks.

// File: rtl/ahbl_ws_pkg.sv
package ahbl_ws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DONE,
        ST_ERR_LO,
        ST_ERR_HI
    } slv_state_e;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;
endpackage

// File: rtl/ahbl_ws_capture.sv
module ahbl_ws_capture #(
    parameter int ADDR_W   = 13,
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    output logic              in_hit,
    output logic              cap_write,
    output logic [IDX_W-1:0]  cap_idx
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_REGS);

    logic [WORD_W-1:0] word_off;

    assign word_off = haddr[ADDR_W-1:2];
    assign in_hit   = (word_off < LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_write <= 1'b0;
            cap_idx   <= '0;
        end else if (accept) begin
            cap_write <= hwrite;
            cap_idx   <= word_off[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/ahbl_ws_fsm.sv
module ahbl_ws_fsm
    import ahbl_ws_pkg::*;
#(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              in_hit,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              hreadyout,
    output logic              hresp,
    output logic              data_done
);
    slv_state_e        state, nxt;
    logic [WAIT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE, ST_DONE, ST_ERR_HI: begin
                if (accept) begin
                    if (!in_hit) begin
                        nxt = ST_ERR_LO;
                    end else if (wait_cfg == '0) begin
                        nxt = ST_DONE;
                    end else begin
                        nxt     = ST_WAIT;
                        cnt_nxt = wait_cfg - 1'b1;
                    end
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (cnt == '0) nxt = ST_DONE;
                else           cnt_nxt = cnt - 1'b1;
            end
            ST_ERR_LO: nxt = ST_ERR_HI;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        hreadyout = 1'b1;
        hresp     = RESP_OKAY;
        data_done = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_WAIT:   hreadyout = 1'b0;
            ST_DONE:   data_done = 1'b1;
            ST_ERR_LO: begin hreadyout = 1'b0; hresp = RESP_ERROR; end
            ST_ERR_HI: hresp = RESP_ERROR;
            default:   ;
        endcase
    end

    // R2: a cycle without acceptance leaves the slave ready with OKAY
    p_ignored_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hreadyout && !accept) |=> (hreadyout && !hresp));

    // R3: zero wait states finish in the very next cycle
    p_zero_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_hit && wait_cfg == '0) |=> (hreadyout && !hresp));

    // R3: one wait state gives exactly one low cycle
    p_one_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_hit && wait_cfg == WAIT_W'(1)) |=> !hreadyout ##1 hreadyout);

    // R6: the low error cycle is always followed by the high error cycle
    p_err_two_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    // R8: a wait cycle of a mapped transfer never turns into an error
    p_wait_okay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hreadyout && !hresp) |=> !hresp);
endmodule

// File: rtl/ahbl_ws_regfile.sv
module ahbl_ws_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] q [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q[k] <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))   q[k] <= wr_data;
        end

        // R4: a register only changes in a cycle that writes it
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_idx == IDX_W'(k)) |=> $stable(q[k]));
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = q[k];
        end
    end
endmodule

// File: rtl/ahbl_wait_slave.sv
module ahbl_wait_slave #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int WAIT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              accept;
    logic              in_hit;
    logic              cap_write;
    logic [IDX_W-1:0]  cap_idx;
    logic              data_done;
    logic [DATA_W-1:0] rd_data;

    assign accept = hsel && htrans[1] && hready;

    ahbl_ws_capture #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
    ) u_capture (
        .clk(clk), .rst_n(rst_n), .accept(accept), .haddr(haddr),
        .hwrite(hwrite), .in_hit(in_hit), .cap_write(cap_write),
        .cap_idx(cap_idx)
    );

    ahbl_ws_fsm #(.WAIT_W(WAIT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .in_hit(in_hit),
        .wait_cfg(wait_cfg), .hreadyout(hreadyout), .hresp(hresp),
        .data_done(data_done)
    );

    ahbl_ws_regfile #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(data_done && cap_write),
        .wr_idx(cap_idx), .wr_data(hwdata), .rd_idx(cap_idx),
        .rd_data(rd_data)
    );

    assign hrdata = (data_done && !cap_write) ? rd_data : '0;

    // R5: read data is zero while the data phase is still stretched
    p_rdata_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |-> (hrdata == '0));

    // R7: ready with no error lets the next address be taken at once
    p_pipeline_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_hit && wait_cfg == '0 && hreadyout) |=> hreadyout);
endmodule

// File: tb/test_ahbl_wait_slave.sv
module test_ahbl_wait_slave;
    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hsel = 1'b0;
    logic [ADDR_W-1:0] haddr = '0;
    logic [1:0]        htrans = 2'b00;
    logic              hwrite = 1'b0;
    logic [DATA_W-1:0] hwdata = '0;
    logic [1:0]        wait_cfg = 2'd0;
    logic              hreadyout, hresp;
    logic [DATA_W-1:0] hrdata;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] next_wdata = '0;

    // behavioural reference state
    logic [DATA_W-1:0] mem [NUM_REGS];
    bit m_act, m_err, m_wr, m_estep;
    int m_wait, m_idx;

    always #10 clk = ~clk;

    ahbl_wait_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .WAIT_W(2)
    ) i_ahbl_wait_slave (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata),
        .hready(hreadyout), .wait_cfg(wait_cfg), .hreadyout(hreadyout),
        .hresp(hresp), .hrdata(hrdata)
    );

    function automatic bit exp_ready();
        if (!m_act) return 1'b1;
        if (m_err)  return m_estep;
        return (m_wait == 0);
    endfunction

    function automatic logic [DATA_W-1:0] exp_rdata();
        if (m_act && !m_err && m_wait == 0 && !m_wr) return mem[m_idx];
        return '0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_err = 0; m_wr = 0; m_estep = 0; m_wait = 0; m_idx = 0;
            for (int k = 0; k < NUM_REGS; k++) mem[k] = '0;
        end else begin
            bit rdy;
            int off;
            rdy = exp_ready();
            if (m_act && !m_err && rdy && m_wr) mem[m_idx] = hwdata;
            if (rdy && hsel && htrans[1]) begin
                off     = int'(haddr) / 4;
                m_act   = 1;
                m_wr    = hwrite;
                m_err   = (off >= NUM_REGS);
                m_idx   = m_err ? 0 : off;
                m_wait  = int'(wait_cfg);
                m_estep = 0;
            end else if (rdy) begin
                m_act = 0;
            end else if (m_err) begin
                m_estep = 1;
            end else begin
                m_wait = m_wait - 1;
            end
        end
    end

    // compare all outputs with the model once per cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (hreadyout !== exp_ready()) begin
                errors++;
                $display("FAIL %s hreadyout actual=%0b expected=%0b t=%0t",
                         m_err ? "R6" : (m_act ? "R3/R7" : "R2"),
                         hreadyout, exp_ready(), $time);
            end
            checks++;
            if (hresp !== (m_act && m_err)) begin
                errors++;
                $display("FAIL %s hresp actual=%0b expected=%0b t=%0t",
                         m_err ? "R6" : "R8", hresp, m_act && m_err, $time);
            end
            checks++;
            if (hrdata !== exp_rdata()) begin
                errors++;
                $display("FAIL R4/R5 hrdata actual=%h expected=%h t=%0t",
                         hrdata, exp_rdata(), $time);
            end
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired, all requirements, actual=hung expected=done");
            summary();
        end
    end

    // one address phase; returns right before the accepting edge
    task automatic issue(input bit sel, input logic [1:0] tr,
                         input logic [ADDR_W-1:0] a, input bit wr,
                         input logic [DATA_W-1:0] wd, input logic [1:0] wc);
        @(negedge clk);
        hwdata   = next_wdata;
        hsel     = sel;
        htrans   = tr;
        haddr    = a;
        hwrite   = wr;
        wait_cfg = wc;
        while (!hreadyout) @(negedge clk);
        next_wdata = wd;
    endtask

    task automatic idle_cycle();
        issue(1'b0, 2'b00, '0, 1'b0, '0, 2'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs at reset
        checks++;
        if (hreadyout !== 1'b1 || hresp !== 1'b0 || hrdata !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%0b/%0b/%h expected=1/0/0",
                     hreadyout, hresp, hrdata);
        end
        rst_n = 1'b1;

        // R1: registers read zero after reset
        for (int k = 0; k < NUM_REGS; k++)
            issue(1'b1, 2'b10, ADDR_W'(k * 4), 1'b0, '0, 2'd0);
        idle_cycle();

        // R3 R4 R7: writes, every wait count, back to back
        for (int k = 0; k < NUM_REGS; k++)
            issue(1'b1, 2'b10, ADDR_W'(k * 4), 1'b1,
                  32'hA5A5_0000 + DATA_W'(k * 17), 2'(k));
        // R5: reads back, with byte offsets in haddr[1:0]
        for (int k = 0; k < NUM_REGS; k++)
            issue(1'b1, 2'b10, ADDR_W'(k * 4 + (k % 4)), 1'b0, '0, 2'(3 - (k % 4)));
        idle_cycle();

        // R7: zero-wait back-to-back mix
        for (int k = 0; k < 8; k++)
            issue(1'b1, 2'b11, ADDR_W'((k % NUM_REGS) * 4), k[0],
                  32'h1234_5600 + DATA_W'(k), 2'd0);
        idle_cycle();

        // R2: ignored cycles (IDLE, BUSY, deselected write), then readback
        issue(1'b1, 2'b00, 13'h0004, 1'b1, 32'hDEAD_0001, 2'd3);
        issue(1'b1, 2'b01, 13'h0008, 1'b1, 32'hDEAD_0002, 2'd3);
        issue(1'b0, 2'b10, 13'h000C, 1'b1, 32'hDEAD_0003, 2'd3);
        issue(1'b0, 2'b11, 13'h0010, 1'b1, 32'hDEAD_0004, 2'd0);
        for (int k = 0; k < NUM_REGS; k++)
            issue(1'b1, 2'b10, ADDR_W'(k * 4), 1'b0, '0, 2'd1);
        idle_cycle();

        // R6: unmapped offsets, boundary and window top, writes and reads
        issue(1'b1, 2'b10, ADDR_W'(NUM_REGS * 4), 1'b1, 32'hBAD0_0001, 2'd2);
        issue(1'b1, 2'b10, 13'h1FFC, 1'b0, '0, 2'd0);
        issue(1'b1, 2'b10, ADDR_W'(NUM_REGS * 4 - 4), 1'b1, 32'h0000_BEEF, 2'd0);
        issue(1'b1, 2'b10, ADDR_W'(NUM_REGS * 4 + 3), 1'b1, 32'hBAD0_0002, 2'd3);
        issue(1'b1, 2'b10, 13'h0400, 1'b1, 32'hBAD0_0003, 2'd1);
        // R6 R8: mapped readback after errors
        for (int k = 0; k < NUM_REGS; k++)
            issue(1'b1, 2'b10, ADDR_W'(k * 4), 1'b0, '0, 2'(k % 3));
        idle_cycle();
        idle_cycle();
        repeat (2) @(negedge clk);
        summary();
    end
endmodule